// File: doc/BRIEF.md
# Serial Receive Queue Register Block

This block sits between a serial receiver and a processor register bus. Each byte the receiver delivers goes into a small circular queue. Software can read the oldest byte in two ways. One register address only looks at the byte. A second address returns the same word and removes the byte from the queue. Both words also carry a data-available flag and two transmitter flags that are always set.

The block keeps a small interrupt cause register. The cause for received data is not stored: it is derived from queue occupancy on every cycle. Writing to the transmit data register raises two transmit causes and arms a one-shot guard. Because of this guard, the first acknowledge after a transmit cannot clear the transmit-done cause. A mask register selects which causes drive the single interrupt line.

Toward the receiver, the block reports free space and a ready flag. Both are gated by the receive-enable bit in the control register.

Top module: `uart_rxq_regs`

## Requirements
- R1: The queue holds 16 bytes. Bytes leave in arrival order, including after the write position wraps from 15 back to 0.
- R2: A read of byte address 0x08 (peek) returns a status word. Bits [7:0] hold the oldest byte. Bit 16 (data available) is 1 exactly when the queue is non-empty. Bits 17 and 18 (transmitter ready, transmitter idle) are always 1. All other bits are 0. The read leaves the queue unchanged.
- R3: A read of byte address 0x0C (pop) returns the same word as a peek. When the queue is non-empty, the read also removes the oldest byte. A pop on an empty queue changes nothing.
- R4: When `rx_valid` is asserted while the queue holds 16 bytes, the byte is discarded and the queue contents are unchanged.
- R5: `rx_free` equals 16 minus the fill count when bit 3 of the control register (byte address 0x04) is set, and 0 otherwise. `rx_ready` is 1 exactly when `rx_free` is non-zero.
- R6: Cause bit 3 reads as 1 whenever the queue is non-empty and as 0 when it is empty. An acknowledge cannot clear it.
- R7: The masked-cause register (0x18) equals the cause register (0x10) ANDed with the mask register (0x14). `irq` is the OR of the masked causes.
- R8: Any write to the transmit data register (0x00) sets cause bits 0 and 1 and arms the transmit guard.
- R9: A write to the acknowledge register (0x1C) clears the cause bits set in the write data, with one exception. If the guard is armed, bit 0 is not cleared, and the guard is disarmed. A later acknowledge of bit 0 then clears it.
- R10: The register index is the byte address shifted right by 2. Reads return the stored value for the transmit data, control and mask registers. The acknowledge register and any unmapped address read as 0. Writes to unmapped addresses have no effect.
- R11: When a byte arrives in the same cycle as a pop of a non-empty, non-full queue, the popped word holds the old head, the new byte is stored, and the fill count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| bus_addr | input | ADDR_W | Register byte address |
| bus_rd | input | 1 | Read strobe; a pop takes effect at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during `bus_rd` |
| rx_ready | output | 1 | Receiver may deliver a byte |
| rx_free | output | $clog2(DEPTH+1) | Free queue slots offered to the receiver |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue so the write position wraps, then pushes one more byte. A design that wrapped the head index wrongly would return bytes out of order. A design that accepted the extra byte would lose the oldest one. The bench pops an empty queue and then pushes a single byte. If the fill count could go negative, the bench would see data-available on the following read or a wrong head byte. It also pushes and pops in the same cycle, which exposes a design that applies only one of the two updates. The transmit sequence acknowledges bit 0 twice, and then acknowledges only bit 1 after a second transmit. A design that ignored the guard, or failed to disarm it, would then show the wrong value in cause bit 0.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int CAUSE_W = 4;
    localparam int IDX_W   = 4;

    localparam int STAT_AVAIL  = 16;
    localparam int STAT_TXRDY  = 17;
    localparam int STAT_TXIDLE = 18;

    localparam int CAUSE_TXDONE  = 0;
    localparam int CAUSE_TXEMPTY = 1;
    localparam int CAUSE_RXDATA  = 3;

    localparam int CTRL_RXEN = 3;

    typedef enum logic [IDX_W-1:0] {
        REG_TXDATA = 4'd0,
        REG_RXCTRL = 4'd1,
        REG_PEEK   = 4'd2,
        REG_POP    = 4'd3,
        REG_CAUSE  = 4'd4,
        REG_MASK   = 4'd5,
        REG_MASKED = 4'd6,
        REG_ACK    = 4'd7
    } reg_idx_e;

    typedef struct packed {
        logic              tx_wr;
        logic              ack_wr;
        logic [CAUSE_W-1:0] ack_val;
    } irq_evt_t;

    function automatic logic [WORD_W-1:0] status_word(input logic [BYTE_W-1:0] head,
                                                      input logic avail);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BYTE_W-1:0]  = head;
        w[STAT_AVAIL]  = avail;
        w[STAT_TXRDY]  = 1'b1;
        w[STAT_TXIDLE] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_pos;
    logic [PTR_W-1:0] head_idx;
    logic             push_ok;
    logic             pop_ok;

    assign push_ok   = push && (count < FULL_CNT);
    assign pop_ok    = pop && (count != '0);
    assign head_idx  = wr_pos - count[PTR_W-1:0];
    assign head_data = mem[head_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_pos] <= push_data;
                wr_pos      <= wr_pos + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == FULL_CNT) |=> (count == FULL_CNT && $stable(wr_pos))); // R4

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> (count == '0)); // R3

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (push && pop && count != '0 && count != FULL_CNT) |=> $stable(count)); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count <= FULL_CNT)); // R1

endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
    import uart_rxq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_nonempty,
    input  irq_evt_t           evt,
    input  logic [CAUSE_W-1:0] mask,
    output logic [CAUSE_W-1:0] cause,
    output logic [CAUSE_W-1:0] masked,
    output logic               irq
);

    logic [CAUSE_W-1:0] latched_q;
    logic               guard_q;
    logic [CAUSE_W-1:0] ack_eff;

    always_comb begin
        ack_eff = evt.ack_val;
        if (guard_q) ack_eff[CAUSE_TXDONE] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_q <= '0;
            guard_q   <= 1'b0;
        end else if (evt.tx_wr) begin
            latched_q[CAUSE_TXDONE]  <= 1'b1;
            latched_q[CAUSE_TXEMPTY] <= 1'b1;
            guard_q                  <= 1'b1;
        end else if (evt.ack_wr) begin
            latched_q <= latched_q & ~ack_eff;
            guard_q   <= 1'b0;
        end
    end

    always_comb begin
        cause               = latched_q;
        cause[CAUSE_RXDATA] = rx_nonempty;
    end

    assign masked = cause & mask;
    assign irq    = |masked;

    AST_TX_RAISE: assert property (@(posedge clk) disable iff (rst)
        evt.tx_wr |=> (cause[CAUSE_TXDONE] && cause[CAUSE_TXEMPTY])); // R8

    AST_ACK_GUARD: assert property (@(posedge clk) disable iff (rst)
        (evt.ack_wr && !evt.tx_wr && guard_q && cause[CAUSE_TXDONE]) |=> cause[CAUSE_TXDONE]); // R9

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt.ack_wr && !evt.tx_wr && !guard_q && evt.ack_val[CAUSE_TXDONE]) |=> !cause[CAUSE_TXDONE]); // R9

endmodule

// File: rtl/uart_rxq_regs.sv
module uart_rxq_regs
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rx_ready,
    output logic [CNT_W-1:0]  rx_free,
    output logic              irq
);

    localparam int RIDX_W = ADDR_W - 2;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [RIDX_W-1:0]  idx;
    logic [WORD_W-1:0]  tx_q;
    logic [WORD_W-1:0]  ctrl_q;
    logic [CAUSE_W-1:0] mask_q;
    logic [BYTE_W-1:0]  head;
    logic [CNT_W-1:0]   fill;
    logic [CAUSE_W-1:0] cause;
    logic [CAUSE_W-1:0] masked;
    logic [WORD_W-1:0]  stat;
    logic               pop;
    irq_evt_t           evt;
    logic               unused_addr;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign unused_addr = ^bus_addr[1:0];

    function automatic logic hit(input logic [RIDX_W-1:0] i, input reg_idx_e r);
        return i == RIDX_W'(r);
    endfunction

    assign pop         = bus_rd && hit(idx, REG_POP);
    assign evt.tx_wr   = bus_wr && hit(idx, REG_TXDATA);
    assign evt.ack_wr  = bus_wr && hit(idx, REG_ACK);
    assign evt.ack_val = bus_wdata[CAUSE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            if (hit(idx, REG_TXDATA)) tx_q   <= bus_wdata;
            if (hit(idx, REG_RXCTRL)) ctrl_q <= bus_wdata;
            if (hit(idx, REG_MASK))   mask_q <= bus_wdata[CAUSE_W-1:0];
        end
    end

    uart_rxq_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid),
        .push_data (rx_byte),
        .pop       (pop),
        .head_data (head),
        .count     (fill)
    );

    uart_rxq_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .rx_nonempty (fill != '0),
        .evt         (evt),
        .mask        (mask_q),
        .cause       (cause),
        .masked      (masked),
        .irq         (irq)
    );

    assign stat     = status_word(head, fill != '0);
    assign rx_free  = ctrl_q[CTRL_RXEN] ? (FULL_CNT - fill) : '0;
    assign rx_ready = rx_free != '0;

    always_comb begin
        bus_rdata = '0;
        if (hit(idx, REG_TXDATA))      bus_rdata = tx_q;
        else if (hit(idx, REG_RXCTRL)) bus_rdata = ctrl_q;
        else if (hit(idx, REG_PEEK))   bus_rdata = stat;
        else if (hit(idx, REG_POP))    bus_rdata = stat;
        else if (hit(idx, REG_CAUSE))  bus_rdata = WORD_W'(cause);
        else if (hit(idx, REG_MASK))   bus_rdata = WORD_W'(mask_q);
        else if (hit(idx, REG_MASKED)) bus_rdata = WORD_W'(masked);
    end

    AST_RX_IRQ: assert property (@(posedge clk) disable iff (rst)
        (fill != '0 && mask_q[CAUSE_RXDATA]) |-> irq); // R7

    AST_POP_AVAIL: assert property (@(posedge clk) disable iff (rst)
        (pop && fill != '0) |-> bus_rdata[STAT_AVAIL]); // R3

    AST_READY_GATE: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_valid && !pop) |=> (fill != '0)); // R5

endmodule

// File: tb/uart_rxq_regs_bench.sv
module uart_rxq_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_ready;
    logic [4:0]  rx_free;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] A_TX = 8'h00, A_CTRL = 8'h04, A_PEEK = 8'h08, A_POP = 8'h0C,
                           A_CAUSE = 8'h10, A_MASK = 8'h14, A_MASKED = 8'h18, A_ACK = 8'h1C;

    always #2 clk = ~clk;

    uart_rxq_regs u_uart_rxq_regs (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_ready(rx_ready), .rx_free(rx_free), .irq(irq)
    );

    function automatic logic [31:0] exp_stat(input logic avail, input logic [7:0] b);
        return 32'h0006_0000 | (32'(avail) << 16) | 32'(b);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        rd(A_PEEK, r);
        check("R2 reset peek", r & 32'hFFFF_FF00, 32'h0006_0000);
        check("R7 reset irq", 32'(irq), 0);
        check("R5 reset rx_free", 32'(rx_free), 0);
        check("R5 reset rx_ready", 32'(rx_ready), 0);
    endtask

    task automatic t_enable();
        logic [31:0] r;
        wr(A_CTRL, 32'h1);
        check("R5 wrong enable bit", 32'(rx_ready), 0);
        wr(A_CTRL, 32'h8);
        check("R5 enabled ready", 32'(rx_ready), 1);
        check("R5 enabled free", 32'(rx_free), 16);
        rd(A_CTRL, r);
        check("R10 ctrl readback", r, 32'h8);
    endtask

    task automatic t_peek();
        logic [31:0] r;
        push(8'hA1); push(8'hB2); push(8'hC3);
        rd(A_PEEK, r);
        check("R2 peek first", r, exp_stat(1'b1, 8'hA1));
        rd(A_PEEK, r);
        check("R2 peek repeat", r, exp_stat(1'b1, 8'hA1));
        check("R5 free after three", 32'(rx_free), 13);
    endtask

    task automatic t_pop_order();
        logic [31:0] r;
        rd(A_POP, r); check("R3 pop 1", r, exp_stat(1'b1, 8'hA1));
        rd(A_POP, r); check("R3 pop 2", r, exp_stat(1'b1, 8'hB2));
        rd(A_POP, r); check("R3 pop 3", r, exp_stat(1'b1, 8'hC3));
        rd(A_POP, r); check("R3 pop empty", r & 32'hFFFF_FF00, 32'h0006_0000);
        check("R3 free after empty pop", 32'(rx_free), 16);
        push(8'hD4);
        rd(A_PEEK, r); check("R3 head after empty pop", r, exp_stat(1'b1, 8'hD4));
        rd(A_POP, r);  check("R3 pop single", r, exp_stat(1'b1, 8'hD4));
    endtask

    task automatic t_full_wrap();
        logic [31:0] r;
        for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
        check("R5 full free", 32'(rx_free), 0);
        check("R5 full ready", 32'(rx_ready), 0);
        push(8'hEE);
        rd(A_PEEK, r); check("R4 head kept when full", r, exp_stat(1'b1, 8'h30));
        for (int i = 0; i < 16; i++) begin
            rd(A_POP, r);
            check("R1 wrap order", r, exp_stat(1'b1, 8'h30 + 8'(i)));
        end
        rd(A_POP, r); check("R4 dropped byte absent", r & 32'hFFFF_FF00, 32'h0006_0000);
    endtask

    task automatic t_same_cycle();
        logic [31:0] r;
        push(8'h55);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h66; bus_addr = A_POP; bus_rd = 1'b1;
        #1 r = bus_rdata;
        @(posedge clk); #1;
        rx_valid = 1'b0; bus_rd = 1'b0;
        check("R11 popped old head", r, exp_stat(1'b1, 8'h55));
        check("R11 count unchanged", 32'(rx_free), 15);
        rd(A_PEEK, r); check("R11 new byte stored", r, exp_stat(1'b1, 8'h66));
        rd(A_POP, r);
    endtask

    task automatic t_rx_irq();
        logic [31:0] r;
        wr(A_MASK, 32'h8);
        check("R7 empty no irq", 32'(irq), 0);
        push(8'h77);
        check("R7 rx irq", 32'(irq), 1);
        rd(A_CAUSE, r);  check("R6 cause nonempty", r, 32'h8);
        rd(A_MASKED, r); check("R7 masked rx", r, 32'h8);
        wr(A_ACK, 32'h8);
        rd(A_CAUSE, r);  check("R6 ack ignored", r, 32'h8);
        rd(A_POP, r);
        rd(A_CAUSE, r);  check("R6 cause empty", r, 32'h0);
        check("R7 irq drops", 32'(irq), 0);
    endtask

    task automatic t_tx_ack();
        logic [31:0] r;
        wr(A_MASK, 32'h1);
        wr(A_TX, 32'h41);
        rd(A_CAUSE, r);  check("R8 tx causes", r, 32'h3);
        check("R7 tx irq", 32'(irq), 1);
        rd(A_MASKED, r); check("R7 masked tx", r, 32'h1);
        wr(A_ACK, 32'h3);
        rd(A_CAUSE, r);  check("R9 first ack keeps bit0", r, 32'h1);
        check("R9 irq held", 32'(irq), 1);
        wr(A_ACK, 32'h1);
        rd(A_CAUSE, r);  check("R9 second ack clears", r, 32'h0);
        check("R9 irq cleared", 32'(irq), 0);
        wr(A_TX, 32'h42);
        wr(A_ACK, 32'h2);
        rd(A_CAUSE, r);  check("R9 ack bit1 only", r, 32'h1);
        wr(A_ACK, 32'h1);
        rd(A_CAUSE, r);  check("R9 guard disarmed", r, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] r;
        rd(A_TX, r);    check("R10 tx readback", r, 32'h42);
        rd(A_MASK, r);  check("R10 mask readback", r, 32'h1);
        rd(A_ACK, r);   check("R10 ack reads zero", r, 32'h0);
        rd(8'h3C, r);   check("R10 unmapped read", r, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(A_CTRL, r);  check("R10 unmapped write ignored", r, 32'h8);
        rd(A_MASK, r);  check("R10 unmapped write mask", r, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_enable();
        t_peek();
        t_pop_order();
        t_full_wrap();
        t_same_cycle();
        t_rx_irq();
        t_tx_ack();
        t_map();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule